// File: doc/BRIEF.md
# Serial Command Decoder with Deferred Register Readback

This block is the slave side of a four-wire serial link made of a frame strobe (`sync_n`, active low), a bit clock (`sclk`), serial data in (`din`) and serial data out (`dout`). The block oversamples all three inputs with the system clock. A ten-bit command carries a two-bit mode, a calibrate flag, an offset-channel select, a test flag and a five-bit channel address. Depending on the mode, the block sends a one-cycle acquire request to the channel sequencer. It may also arm a readback, which shifts the fourteen-bit code of the target channel out on `dout` during the next frame. The codes are held in a local file of 33 fourteen-bit words: 32 address channels plus one offset channel. The sequencer writes that file through a simple write port.

An illegal mode, or a set test flag, traps the block. While it is trapped, every command is ignored. Only a frame of exactly 24 bit clocks releases the trap. In acquire-then-read mode, the readback is only valid once the sequencer has finished acquiring, which the sequencer reports by raising `seq_busy_n`. If the readback frame starts while `seq_busy_n` is still low, the block shifts out zeros and raises a late-read flag.

The controller is one state machine with six states:
- `ST_IDLE` waits for `sync_n` to fall and then goes to `ST_CMD`.
- `ST_CMD` collects bits. When `sync_n` rises it goes to one of three states:
  - `ST_TRAP` for a 10-bit frame with an illegal mode or a set test flag.
  - `ST_ARMED` for a 10-bit frame in either readback mode.
  - `ST_IDLE` in every other case.
- `ST_ARMED` goes to `ST_READ` when `sync_n` falls, and loads the shifter there.
- `ST_READ` drives `dout` and goes back to `ST_IDLE` when `sync_n` rises.
- `ST_TRAP` goes to `ST_CLEAR` when `sync_n` falls.
- `ST_CLEAR` goes to `ST_IDLE` when `sync_n` rises after exactly 24 bit clocks, and otherwise returns to `ST_TRAP`.

Top module: `sif_cmd_port`

## Requirements
- R1: A command is 10 bits, sent MSB first and sampled on SCLK falling edges while SYNC is low. Bits 9:8 are the mode (first on the wire), bit 7 is cal, bit 6 is offset select, bit 5 is test, and bits 4:0 are the address, with the channel address MSB at bit 4.
- R2: Mode 00 in a 10-bit frame produces one acq_go pulse, one clock wide, after SYNC rises, with acq_all=0 and acq_chan set to the target channel.
- R3: With cal=1, an acquiring command gives acq_all=1 and acq_chan=0, whatever the address and offset bits are.
- R4: With offset select=1, the target channel is 32 (the offset channel) for both acquire and readback, and the address bits are ignored.
- R5: Mode 11 does not acquire. The next SYNC frame shifts the target channel's 14-bit code out MSB first, with DOUT updated on SCLK rising edges.
- R6: Mode 10 acquires and arms a readback. If seq_busy_n is high when the readback frame starts, the stored code is shifted out.
- R7: In mode 10, if the readback frame starts while seq_busy_n is low, DOUT sends all zeros and late_err becomes 1. Every readback frame start updates late_err, so a valid read clears it.
- R8: dout_oe is high only inside the armed readback frame. It is low while SYNC is high and when no readback is armed. The readback frame uses up the armed readback whatever its length.
- R9: A command frame whose bit count is not 10 is discarded: no acquire, no readback armed.
- R10: Mode 01, or test=1, sets test_trap. While test_trap is set, command frames produce no acquire and no readback.
- R11: Only a frame of exactly 24 SCLK cycles clears test_trap. A frame of any other length leaves it set.
- R12: When wr_en is high, wr_code is stored into channel wr_chan (0 to 32), and later readbacks return that value.
- R13: After reset, acq_go, dout_oe, test_trap and late_err are 0, and every stored code is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Frame strobe, a frame lasts while it is low |
| sclk | input | 1 | Serial bit clock, idles low |
| din | input | 1 | Serial command data |
| seq_busy_n | input | 1 | Low while the sequencer is acquiring |
| wr_en | input | 1 | Code write strobe from the sequencer |
| wr_chan | input | 6 | Channel to write, 0 to 32 |
| wr_code | input | 14 | Code to store |
| dout | output | 1 | Serial readback data |
| dout_oe | output | 1 | Output enable for dout; when low, dout is treated as high impedance |
| acq_go | output | 1 | One-cycle acquire request |
| acq_all | output | 1 | Acquire request covers all channels |
| acq_chan | output | 6 | Channel to acquire, 32 is the offset channel |
| test_trap | output | 1 | Block is trapped by an illegal command |
| late_err | output | 1 | Last readback started before acquisition ended |

## Verification
The hardest case to reach is a readback frame that begins while the acquisition it depends on is still running. The bench's sequencer model holds `seq_busy_n` low for a fixed time after each acquire pulse. Issuing an acquire-then-read command and starting the readback frame right after it lands inside that window. Waiting past the window gives the valid read to compare against. The trap is driven the same way: a frame of 23 clocks, a normal command and a readback attempt all have to leave it set, and only the 24-clock frame may release it.

// File: rtl/sif_pkg.sv
package sif_pkg;
    localparam int CMD_ADDR_W = 5;

    typedef enum logic [1:0] {
        MODE_ACQ    = 2'b00,
        MODE_BAD    = 2'b01,
        MODE_ACQ_RD = 2'b10,
        MODE_RD     = 2'b11
    } mode_e;

    typedef struct packed {
        mode_e                 mode;
        logic                  cal;
        logic                  offs;
        logic                  test;
        logic [CMD_ADDR_W-1:0] addr;
    } cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ARMED,
        ST_READ,
        ST_TRAP,
        ST_CLEAR
    } state_e;
endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], raw[b]};
        end
        assign lvl[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/sif_regfile.sv
module sif_regfile #(
    parameter int DEPTH = 33,
    parameter int DW    = 14,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] word [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               word[i] <= '0;
            else if (wr_en && wr_addr == AW'(i))      word[i] <= wr_data;
        end
    end

    assign rd_data = (int'(rd_addr) < DEPTH) ? word[rd_addr] : '0;

    // R12
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> int'(wr_addr) < DEPTH);
endmodule

// File: rtl/sif_txshift.sv
module sif_txshift #(
    parameter int DW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          shift,
    output logic          dout
);
    logic [DW-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr   <= '0;
            dout <= 1'b0;
        end else if (load) begin
            sr   <= load_val;
            dout <= 1'b0;
        end else if (shift) begin
            dout <= sr[DW-1];
            sr   <= {sr[DW-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/sif_cmd_port.sv
module sif_cmd_port
    import sif_pkg::*;
#(
    parameter int NCHAN       = 32,
    parameter int CODE_W      = 14,
    parameter int CLR_BITS    = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sync_n,
    input  logic                        sclk,
    input  logic                        din,
    input  logic                        seq_busy_n,
    input  logic                        wr_en,
    input  logic [$clog2(NCHAN+1)-1:0]  wr_chan,
    input  logic [CODE_W-1:0]           wr_code,
    output logic                        dout,
    output logic                        dout_oe,
    output logic                        acq_go,
    output logic                        acq_all,
    output logic [$clog2(NCHAN+1)-1:0]  acq_chan,
    output logic                        test_trap,
    output logic                        late_err
);
    localparam int CH_W     = $clog2(NCHAN + 1);
    localparam int CMD_BITS = $bits(cmd_t);
    localparam int CNT_W    = $clog2(CLR_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // ---------------- input synchronisation ----------------
    logic [2:0] in_lvl;
    sif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({sync_n, sclk, din}),
        .lvl   (in_lvl)
    );

    logic [1:0] ctl_prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_prev <= 2'b10;
        else        ctl_prev <= in_lvl[2:1];
    end

    logic sync_hi, sync_fall, sync_rise, sclk_rise, sclk_fall, din_bit;
    assign sync_hi   = in_lvl[2];
    assign sync_fall = ctl_prev[1] & ~in_lvl[2];
    assign sync_rise = ~ctl_prev[1] & in_lvl[2];
    assign sclk_rise = ~ctl_prev[0] & in_lvl[1];
    assign sclk_fall = ctl_prev[0] & ~in_lvl[1];
    assign din_bit   = in_lvl[0];

    // ---------------- bit counter and command shifter ----------------
    logic [CNT_W-1:0]    bit_cnt;
    logic [CMD_BITS-1:0] rx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx      <= '0;
        end else if (sync_fall) begin
            bit_cnt <= '0;
        end else if (sclk_fall && !sync_hi) begin
            if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
            rx <= {rx[CMD_BITS-2:0], din_bit};
        end
    end

    cmd_t            cmd;
    logic            len_cmd, len_clr, cmd_bad, cmd_acq, cmd_rd;
    logic [CH_W-1:0] tgt_chan;

    assign cmd      = cmd_t'(rx);
    assign len_cmd  = (bit_cnt == CNT_W'(CMD_BITS));
    assign len_clr  = (bit_cnt == CNT_W'(CLR_BITS));
    assign cmd_bad  = (cmd.mode == MODE_BAD) || cmd.test;
    assign cmd_acq  = !cmd_bad && (cmd.mode == MODE_ACQ || cmd.mode == MODE_ACQ_RD);
    assign cmd_rd   = !cmd_bad && (cmd.mode == MODE_RD || cmd.mode == MODE_ACQ_RD);
    assign tgt_chan = cmd.offs ? CH_W'(NCHAN) : CH_W'(cmd.addr);

    // ---------------- state register ----------------
    state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (sync_fall) nxt = ST_CMD;
            ST_CMD: begin
                if (sync_rise) begin
                    if (len_cmd && cmd_bad)     nxt = ST_TRAP;
                    else if (len_cmd && cmd_rd) nxt = ST_ARMED;
                    else                        nxt = ST_IDLE;
                end
            end
            ST_ARMED: if (sync_fall) nxt = ST_READ;
            ST_READ:  if (sync_rise) nxt = ST_IDLE;
            ST_TRAP:  if (sync_fall) nxt = ST_CLEAR;
            ST_CLEAR: if (sync_rise) nxt = len_clr ? ST_IDLE : ST_TRAP;
            default:  nxt = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    logic              rd_after_acq;
    logic [CH_W-1:0]   rd_chan;
    logic              late_now, tx_load, tx_shift;
    logic [CODE_W-1:0] rf_data;

    assign late_now = rd_after_acq && !seq_busy_n;
    assign tx_load  = (state == ST_ARMED) && sync_fall;
    assign tx_shift = (state == ST_READ) && sclk_rise && !sync_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acq_go       <= 1'b0;
            acq_all      <= 1'b0;
            acq_chan     <= '0;
            rd_after_acq <= 1'b0;
            rd_chan      <= '0;
            late_err     <= 1'b0;
        end else begin
            acq_go <= 1'b0;
            if (state == ST_CMD && sync_rise && len_cmd) begin
                if (cmd_acq) begin
                    acq_go   <= 1'b1;
                    acq_all  <= cmd.cal;
                    acq_chan <= cmd.cal ? '0 : tgt_chan;
                end
                if (cmd_rd) begin
                    rd_chan      <= tgt_chan;
                    rd_after_acq <= (cmd.mode == MODE_ACQ_RD);
                end
            end
            if (tx_load) late_err <= late_now;
        end
    end

    assign dout_oe   = (state == ST_READ);
    assign test_trap = (state == ST_TRAP) || (state == ST_CLEAR);

    sif_regfile #(.DEPTH(NCHAN + 1), .DW(CODE_W)) u_codes (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_chan),
        .wr_data (wr_code),
        .rd_addr (rd_chan),
        .rd_data (rf_data)
    );

    sif_txshift #(.DW(CODE_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tx_load),
        .load_val (late_now ? '0 : rf_data),
        .shift    (tx_shift),
        .dout     (dout)
    );

    // ---------------- assertions ----------------
    // R8
    oe_sync_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> !ctl_prev[1]);
    // R2
    acq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_go |=> !acq_go);
    // R3
    cal_chan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_go && acq_all) |-> (acq_chan == '0));
    // R4
    acq_chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_go |-> (int'(acq_chan) <= NCHAN));
    // R10
    trap_no_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_trap |-> !acq_go);
    // R11
    trap_clear_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(test_trap) |-> ($past(bit_cnt) == CNT_W'(CLR_BITS)));
    // R7
    late_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && late_err) |-> !dout);
endmodule

// File: tb/sif_cmd_port_test.sv
module sif_cmd_port_test;
    localparam int BUSY_CYC = 100;
    localparam int HALF     = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic        seq_busy_n = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_chan = '0;
    logic [13:0] wr_code = '0;
    logic        dout, dout_oe, acq_go, acq_all, test_trap, late_err;
    logic [5:0]  acq_chan;

    always #5 clk = ~clk;

    sif_cmd_port uut (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .din(din),
        .seq_busy_n(seq_busy_n), .wr_en(wr_en), .wr_chan(wr_chan), .wr_code(wr_code),
        .dout(dout), .dout_oe(dout_oe), .acq_go(acq_go), .acq_all(acq_all),
        .acq_chan(acq_chan), .test_trap(test_trap), .late_err(late_err)
    );

    typedef struct packed { logic all; logic [5:0] chan; } acq_t;
    acq_t        acq_q[$];
    logic [13:0] rd_q[$];
    int n_chk = 0;
    int n_bad = 0;
    int busy_cnt = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: acquire scoreboard and sequencer busy model
    always @(negedge clk) begin
        if (!rst_n) begin
            busy_cnt = 0;
        end else if (acq_go) begin
            if (acq_q.size() == 0) begin
                chk(1'b0, "R9/R10 unexpected acquire", {acq_all, acq_chan}, 0);
            end else begin
                acq_t e;
                e = acq_q.pop_front();
                chk({acq_all, acq_chan} == e, "R2 acquire target", {acq_all, acq_chan}, e);
            end
            busy_cnt = BUSY_CYC;
        end else if (busy_cnt > 0) begin
            busy_cnt--;
        end
        seq_busy_n = (busy_cnt == 0);
    end

    function automatic logic [9:0] mk(input logic [1:0] m, input logic c, input logic o,
                                      input logic t, input logic [4:0] a);
        return {m, c, o, t, a};
    endfunction

    task automatic send_frame(input logic [23:0] bits, input int n);
        sync_n = 1'b0;
        wclk(HALF);
        for (int i = 0; i < n; i++) begin
            din  = bits[n-1-i];
            sclk = 1'b1;
            wclk(HALF);
            sclk = 1'b0;
            wclk(HALF);
        end
        wclk(4);
        sync_n = 1'b1;
        wclk(12);
    endtask

    task automatic send_cmd(input logic [9:0] c);
        send_frame({14'd0, c}, 10);
    endtask

    task automatic read_frame(input bit expect_rd, input string tag);
        logic [13:0] got = '0;
        logic [13:0] exp = '0;
        bit oe_all = 1'b1;
        bit oe_any = 1'b0;
        if (expect_rd) exp = rd_q.pop_front();
        sync_n = 1'b0;
        wclk(HALF);
        for (int i = 0; i < 14; i++) begin
            sclk = 1'b1;
            wclk(HALF);
            got = {got[12:0], dout};
            oe_all &= dout_oe;
            oe_any |= dout_oe;
            sclk = 1'b0;
            wclk(HALF);
        end
        wclk(4);
        sync_n = 1'b1;
        wclk(12);
        if (expect_rd) begin
            chk(got == exp, tag, got, exp);
            chk(oe_all, "R8 oe held through readback", oe_all, 1);
        end else begin
            chk(!oe_any, tag, oe_any, 0);
        end
        chk(!dout_oe, "R8 oe low after frame", dout_oe, 0);
    endtask

    task automatic wr(input logic [5:0] ch, input logic [13:0] code);
        wr_en = 1'b1; wr_chan = ch; wr_code = code;
        wclk(1);
        wr_en = 1'b0;
    endtask

    initial begin
        wclk(5);
        rst_n = 1'b1;
        wclk(5);
        // R13 reset state
        chk(!acq_go && !dout_oe && !test_trap && !late_err, "R13 reset outputs",
            {acq_go, dout_oe, test_trap, late_err}, 0);
        send_cmd(mk(2'b11, 0, 0, 0, 5'd2));
        rd_q.push_back(14'h0);
        read_frame(1, "R13 reset code zero");

        // R12 writes
        wr(6'd5, 14'h1ABC);
        wr(6'd32, 14'h2D5A);
        wr(6'd31, 14'h3FFF);
        wr(6'd0, 14'h0001);

        // R1 R2 plain acquire
        acq_q.push_back({1'b0, 6'd7});
        send_cmd(mk(2'b00, 0, 0, 0, 5'd7));
        acq_q.push_back({1'b0, 6'd22});
        send_cmd(mk(2'b00, 0, 0, 0, 5'd22));
        // R3 cal ignores address and offset
        acq_q.push_back({1'b1, 6'd0});
        send_cmd(mk(2'b00, 1, 1, 0, 5'd3));
        // R4 offset overrides address
        acq_q.push_back({1'b0, 6'd32});
        send_cmd(mk(2'b00, 0, 1, 0, 5'd9));
        wclk(BUSY_CYC + 5);

        // R5 readback only, R12 written code
        send_cmd(mk(2'b11, 0, 0, 0, 5'd5));
        rd_q.push_back(14'h1ABC);
        read_frame(1, "R5 R12 readback code ch5");
        // R4 readback of offset channel
        send_cmd(mk(2'b11, 0, 1, 0, 5'd3));
        rd_q.push_back(14'h2D5A);
        read_frame(1, "R4 readback offset channel");

        // R6 acquire then read after busy
        acq_q.push_back({1'b0, 6'd31});
        send_cmd(mk(2'b10, 0, 0, 0, 5'd31));
        wclk(BUSY_CYC + 5);
        rd_q.push_back(14'h3FFF);
        read_frame(1, "R6 readback after acquire");
        chk(!late_err, "R6 no late flag", late_err, 0);

        // R7 early read
        acq_q.push_back({1'b0, 6'd0});
        send_cmd(mk(2'b10, 0, 0, 0, 5'd0));
        rd_q.push_back(14'h0);
        read_frame(1, "R7 early read gives zeros");
        chk(late_err, "R7 late flag set", late_err, 1);
        wclk(BUSY_CYC + 5);
        send_cmd(mk(2'b11, 0, 0, 0, 5'd0));
        rd_q.push_back(14'h0001);
        read_frame(1, "R7 valid read after late");
        chk(!late_err, "R7 late flag cleared", late_err, 0);

        // R9 short and long frames discarded
        send_frame({15'd0, 9'h1FF & 9'(mk(2'b11, 0, 0, 0, 5'd5) >> 1)}, 9);
        send_frame({13'd0, mk(2'b00, 0, 0, 0, 5'd4), 1'b0}, 11);
        read_frame(0, "R9 R8 no readback armed after bad length");
        send_frame(24'hABCDEF, 24);
        read_frame(0, "R9 24-bit frame outside trap arms nothing");

        // R10 illegal mode trap
        send_cmd(mk(2'b01, 0, 0, 0, 5'd1));
        chk(test_trap, "R10 trap set by mode 01", test_trap, 1);
        send_cmd(mk(2'b00, 0, 0, 0, 5'd3));
        send_cmd(mk(2'b11, 0, 0, 0, 5'd5));
        read_frame(0, "R10 no readback while trapped");
        send_frame(24'h0, 23);
        chk(test_trap, "R11 23-bit frame keeps trap", test_trap, 1);
        send_frame(24'h0, 24);
        chk(!test_trap, "R11 24-bit frame clears trap", test_trap, 0);
        acq_q.push_back({1'b0, 6'd3});
        send_cmd(mk(2'b00, 0, 0, 0, 5'd3));
        wclk(BUSY_CYC + 5);

        // R10 test bit trap
        send_cmd(mk(2'b00, 0, 0, 1, 5'd6));
        chk(test_trap, "R10 trap set by test bit", test_trap, 1);
        send_frame(24'h123456, 24);
        chk(!test_trap, "R11 trap released", test_trap, 0);

        wclk(20);
        chk(acq_q.size() == 0, "R2 all expected acquires seen", acq_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule